// File: doc/BRIEF.md
# SPI baud rate generator

This block sets the pace of an SPI port. Software writes a 16-bit divisor through a byte-wide register interface. The low byte and the high byte each sit behind their own address. A down-counter running on the system clock uses the divisor to mark the half-periods of the serial clock.

At each half-period boundary the block gives a shift engine a one-cycle toggle strobe and flips a serial clock level. The serial bit rate is therefore the system clock frequency divided by twice the divisor.

A write to either byte loads the whole 16-bit value into the counter at once and restarts the count. A mode input selects master or slave. A status flag reports when the divisor is too small for the selected mode, but the generator keeps running anyway. The divisor value zero stands for 65536.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset the divisor reads back as low byte 0x02 and high byte 0x00, and both `tick_o` and `sck_o` are low.
- R2: A write with `wr_addr`=0 replaces only the low byte (bits 7:0); the high byte reads back unchanged.
- R3: A write with `wr_addr`=1 replaces only the high byte (bits 15:8); the low byte reads back unchanged.
- R4: A write to either byte restarts the count. `tick_o` stays low in the cycle after the write edge. Its first pulse comes exactly D clock edges after the write edge, where D is the new effective divisor.
- R5: With no further writes, `tick_o` pulses for one cycle every D clock edges. When D is 1 it stays high continuously.
- R6: `sck_o` toggles on exactly the edges where `tick_o` is raised and holds otherwise, so one serial clock period is 2·D system clocks.
- R7: A divisor of 0x0000 behaves as D = 65536.
- R8: In master mode (`slave_mode`=0), `bad_div_o` is high exactly when D is below 3.
- R9: In slave mode (`slave_mode`=1), `bad_div_o` is high exactly when D is below 4.
- R10: An illegal divisor does not stop the generator; the strobe keeps its D-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_addr | input | 1 | Byte select for writes: 0 = low, 1 = high |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 1 | Byte select for readback: 0 = low, 1 = high |
| rd_data | output | 8 | Latched divisor byte selected by `rd_addr` |
| slave_mode | input | 1 | 0 = master legality limit, 1 = slave limit |
| sck_o | output | 1 | Serial clock level, toggled each half-period |
| tick_o | output | 1 | One-cycle strobe at each half-period boundary |
| bad_div_o | output | 1 | Divisor below the minimum for the current mode |

## Verification
Two situations are hard to reach from the ports. The first is a zero divisor, which only shows its meaning after 65536 silent cycles. A directed run therefore holds that value long enough to see the first strobe and the absence of any earlier one.

The second is a byte write that lands on the very edge where the counter would reload. The random phase uses small divisors, random gaps (including zero-gap back-to-back writes) and random mode flips. With these, writes fall on every phase of the count, including the reload edge.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    localparam int DIV_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NBYTES = DIV_W / BYTE_W;
    localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int CNT_W  = DIV_W + 1;

    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } spi_mode_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } byte_wr_t;

    typedef struct packed {
        logic tick;
        logic sck;
    } clk_out_t;

    // Zero divisor counts as 2**DIV_W half-period clocks
    function automatic logic [CNT_W-1:0] expand_div(input logic [DIV_W-1:0] d);
        return {(d == '0), d};
    endfunction

endpackage

// File: rtl/spi_rate_latch.sv
module spi_rate_latch
    import spi_rate_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 16'h0002
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_wr_t          wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_d,
    output logic              load
);

    logic [NBYTES-1:0][BYTE_W-1:0] bytes_q;
    logic [NBYTES-1:0][BYTE_W-1:0] bytes_d;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_comb begin
            bytes_d[b] = bytes_q[b];
            if (wr.we && wr.addr == ADDR_W'(b)) begin
                bytes_d[b] = wr.data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[b] <= RESET_DIV[b*BYTE_W +: BYTE_W];
            end else begin
                bytes_q[b] <= bytes_d[b];
            end
        end
    end

    assign div_q   = bytes_q;
    assign div_d   = bytes_d;
    assign load    = wr.we;
    assign rd_data = bytes_q[rd_addr];

endmodule

// File: rtl/spi_rate_counter.sv
module spi_rate_counter
    import spi_rate_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 16'h0002
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_d,
    input  logic [DIV_W-1:0] div_q,
    output clk_out_t         out,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_RESET = expand_div(RESET_DIV);

    clk_out_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= CNT_RESET;
            out_q     <= '0;
        end else if (load) begin
            // restart from the freshly written value
            cnt_q      <= expand_div(div_d);
            out_q.tick <= 1'b0;
        end else if (cnt_q == CNT_ONE) begin
            cnt_q      <= expand_div(div_q);
            out_q.tick <= 1'b1;
            out_q.sck  <= ~out_q.sck;
        end else begin
            cnt_q      <= cnt_q - CNT_ONE;
            out_q.tick <= 1'b0;
        end
    end

    assign out = out_q;

endmodule

// File: rtl/spi_rate_legal.sv
module spi_rate_legal
    import spi_rate_pkg::*;
#(
    parameter int MASTER_MIN = 3,
    parameter int SLAVE_MIN  = 4
) (
    input  logic [DIV_W-1:0] div_q,
    input  spi_mode_e        mode,
    output logic             bad
);

    localparam logic [CNT_W-1:0] LIM_M = CNT_W'(MASTER_MIN);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SLAVE_MIN);

    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] limit;

    always_comb begin
        eff   = expand_div(div_q);
        limit = (mode == MODE_SLAVE) ? LIM_S : LIM_M;
        bad   = eff < limit;
    end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_rate_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV  = 16'h0002,
    parameter int               MASTER_MIN = 3,
    parameter int               SLAVE_MIN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              slave_mode,
    output logic              sck_o,
    output logic              tick_o,
    output logic              bad_div_o
);

    byte_wr_t         wr;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_d;
    logic             load;
    logic [CNT_W-1:0] cnt_q;
    clk_out_t         cout;
    spi_mode_e        mode;

    assign wr   = '{we: wr_en, addr: wr_addr, data: wr_data};
    assign mode = spi_mode_e'(slave_mode);

    spi_rate_latch #(.RESET_DIV(RESET_DIV)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .div_q   (div_q),
        .div_d   (div_d),
        .load    (load)
    );

    spi_rate_counter #(.RESET_DIV(RESET_DIV)) u_count (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .div_d (div_d),
        .div_q (div_q),
        .out   (cout),
        .cnt_q (cnt_q)
    );

    spi_rate_legal #(.MASTER_MIN(MASTER_MIN), .SLAVE_MIN(SLAVE_MIN)) u_legal (
        .div_q (div_q),
        .mode  (mode),
        .bad   (bad_div_o)
    );

    assign tick_o = cout.tick;
    assign sck_o  = cout.sck;

endmodule

// File: rtl/spi_rate_props.sv
module spi_rate_props
    import spi_rate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              tick_o,
    input logic              sck_o,
    input logic [DIV_W-1:0]  div_q,
    input logic [CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {DIV_W{1'b0}}};

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(rst) |-> (!tick_o && !sck_o));

    // R2
    a_r2_low_write_keeps_high: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(wr_en && wr_addr == '0) && !$past(rst))
        |-> div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W]));

    // R3
    a_r3_high_write_keeps_low: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(wr_en && wr_addr != '0) && !$past(rst))
        |-> div_q[BYTE_W-1:0] == $past(div_q[BYTE_W-1:0]));

    // R4
    a_r4_no_tick_after_load: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(wr_en) && !$past(rst)) |-> !tick_o);

    // R6
    a_r6_sck_follows_tick: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(rst) |-> ((sck_o != $past(sck_o)) == tick_o));

    // R7
    a_r7_count_bounds: assert property (@(posedge clk) disable iff (rst || !armed)
        (cnt_q != '0) && (cnt_q <= CNT_MAX));

endmodule

bind spi_rate_gen spi_rate_props u_props (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .tick_o  (tick_o),
    .sck_o   (sck_o),
    .div_q   (div_q),
    .cnt_q   (cnt_q)
);

// File: tb/spi_rate_gen_test.sv
module spi_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       slave_mode = 1'b0;
    logic       sck_o;
    logic       tick_o;
    logic       bad_div_o;

    always #5 clk = ~clk;

    spi_rate_gen uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .slave_mode (slave_mode),
        .sck_o      (sck_o),
        .tick_o     (tick_o),
        .bad_div_o  (bad_div_o)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [15:0] m_div;
    int          m_d;
    int          phase;
    logic        m_tick;
    logic        m_sck;
    logic        m_slave;

    function automatic int eff_of(input logic [15:0] v);
        return (v == 16'h0000) ? 65536 : int'(v);
    endfunction

    function automatic int min_of(input logic slave);
        return slave ? 4 : 3;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input logic after_write);
        string rtag;
        if (after_write || phase <= m_d) rtag = "R4";
        else if (m_d == 65536)           rtag = "R7";
        else if (m_d < min_of(m_slave))  rtag = "R10";
        else                             rtag = "R5";
        check(rtag, "tick", int'(tick_o), int'(m_tick));
        check("R6", "sck", int'(sck_o), int'(m_sck));
        check(rd_addr ? "R3" : "R2", "readback", int'(rd_data),
              int'(rd_addr ? m_div[15:8] : m_div[7:0]));
        check(m_slave ? "R9" : "R8", "bad_div", int'(bad_div_o),
              int'(eff_of(m_div) < min_of(m_slave)));
    endtask

    // one clock: drive after a falling edge, model at the rising edge, sample at the next falling edge
    task automatic cycle(input logic we, input logic a, input logic [7:0] d);
        wr_en      = we;
        wr_addr    = a;
        wr_data    = d;
        rd_addr    = 1'($urandom % 2);
        slave_mode = m_slave;
        @(posedge clk);
        if (we) begin
            if (a) m_div[15:8] = d;
            else   m_div[7:0]  = d;
            m_d    = eff_of(m_div);
            phase  = 0;
            m_tick = 1'b0;
        end else begin
            phase++;
            m_tick = (phase % m_d) == 0;
            if (m_tick) m_sck = ~m_sck;
        end
        @(negedge clk);
        check_outputs(we);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        wr_en = 1'b0;
        slave_mode = 1'b0;
        m_slave = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_addr = 1'b0;
        #1;
        check("R1", "reset low byte", int'(rd_data), 2);
        rd_addr = 1'b1;
        #1;
        check("R1", "reset high byte", int'(rd_data), 0);
        check("R1", "reset tick", int'(tick_o), 0);
        check("R1", "reset sck", int'(sck_o), 0);
        check("R8", "reset flag master", int'(bad_div_o), 1);
        m_div  = 16'h0002;
        m_d    = 2;
        phase  = 0;
        m_tick = 1'b0;
        m_sck  = 1'b0;
        rst    = 1'b0;
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // default divisor 2, illegal for master and slave, still runs (R10)
        idle(10);
        m_slave = 1'b1;
        idle(4);
        m_slave = 1'b0;

        // divisor 1: strobe every cycle (R5, R10)
        cycle(1'b1, 1'b0, 8'h01);
        idle(8);

        // divisor 3: legal for master, illegal for slave (R8, R9)
        cycle(1'b1, 1'b0, 8'h03);
        idle(12);
        m_slave = 1'b1;
        idle(12);

        // divisor 4 in slave mode is legal (R9)
        cycle(1'b1, 1'b0, 8'h04);
        idle(20);

        // high byte write restarts the count (R3, R4)
        cycle(1'b1, 1'b1, 8'h01);
        idle(600);

        // zero divisor behaves as 65536 (R7)
        m_slave = 1'b0;
        cycle(1'b1, 1'b0, 8'h00);
        cycle(1'b1, 1'b1, 8'h00);
        idle(65540);

        // random writes, gaps and modes
        for (int it = 0; it < 400; it++) begin
            logic       a;
            logic [7:0] d;
            a = 1'($urandom % 2);
            if (a) d = ($urandom % 8 == 0) ? 8'h01 : 8'h00;
            else   d = 8'($urandom % 12);
            if ($urandom % 5 == 0) m_slave = ~m_slave;
            cycle(1'b1, a, d);
            idle(int'($urandom % 26));
        end

        // reset again mid-activity
        do_reset();
        idle(6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule